// File: doc/BRIEF.md
# Daisy-Chained Input Serializer Readout Controller

This block reads a chain of `N_DEV` digital-input serializers over a receive-only SPI link. A one-cycle request starts a single transfer with chip select held low. In status mode the transfer returns an input byte and a status byte for each device. In input-only mode it returns just the input byte for each device. When the last byte is in, the block splits the stream by device and recomputes each device's 5-bit check code over its input byte. It then decodes the temperature and supply indications and samples the fault pins.

Each device gets its own health verdict. A broken device therefore does not hide the inputs of the devices around it. The host reads any single input bit by its global index. Each read returns the bit together with a valid flag that is cleared when the owning device is unhealthy. The per-device flag vectors and the raw input bytes are also available as outputs.

Top module: `serin_chain_reader`

## Requirements
- R1: One accepted request runs exactly one transfer. The transfer is `2*N_DEV` bytes when `mode16`=1 and `N_DEV` bytes when `mode16`=0. Each byte takes 8 rising clock edges, chip select stays low for the whole transfer, and a one-cycle `done` pulse is raised as chip select returns high.
- R2: The link runs in SPI mode 0. The serial clock idles low. `miso` is sampled on the rising serial clock edge, most significant bit first. Each serial clock half-period lasts `CLK_DIV` system clocks.
- R3: Byte position 0 is the first byte received. In status mode, device i takes its input byte from position 2i and its status byte from position 2i+1. In input-only mode, device i takes its input byte from position i.
- R4: `crc_err[i]` is set when status bits 7:3 differ from the CRC of the input byte. That CRC uses generator x^5+x^4+x^2+1 with a zero start value, and the input byte is shifted in MSB first.
- R5: `overtemp[i]` is status bit 1 equal to 1, `uv_alarm[i]` is status bit 2 equal to 0, and `uv_warn[i]` is status bit 0 equal to 0. These raw flags do not depend on `ignore_uv`. In input-only mode, `crc_err`, `overtemp`, `uv_alarm` and `uv_warn` all read 0.
- R6: `dev_ok[i]` is 0 if the device's fault pin is high. In status mode it is also 0 on a CRC error, on overtemperature or on an undervoltage alarm. An undervoltage warning never clears `dev_ok[i]`.
- R7: With `ignore_uv`=1, the undervoltage alarm and the fault pin play no part in `dev_ok`. `fault_seen` still records the pin.
- R8: With `SHARED_FAULT`=1, the single bit `fault_in[0]` applies to every device. Otherwise `fault_in[i]` belongs to device i. The pins are sampled in the cycle of `done`, and `fault_seen[i]` holds the sampled value.
- R9: A global index k selects device k/8 and bit k%8 of that device's input byte, where bit 0 is the LSB. `sel_ok` equals that device's `dev_ok`. `sel_bit` is the input bit when `sel_ok`=1 and 0 otherwise. An index of `N_DEV*8` or above gives `sel_ok`=0 and `sel_bit`=0.
- R10: After reset, chip select is high, the serial clock is low, and all flag vectors, `dev_ok` and `in_bits` are 0. Results change only in the cycle after `done` and keep their values throughout a transfer.
- R11: A request while `busy`=1 is ignored. `mode16` and `ignore_uv` are latched when a request is accepted, so changing them mid-transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Start a readout (one cycle) |
| mode16 | input | 1 | 1: input plus status byte per device; 0: input byte only |
| ignore_uv | input | 1 | Leave undervoltage alarm and fault pin out of the verdict |
| fault_in | input | SHARED_FAULT ? 1 : N_DEV | Fault pin(s), high = fault |
| miso | input | 1 | Serial data from the chain |
| sel_idx | input | $clog2(N_DEV*8) | Global input index to read |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| in_bits | output | N_DEV*8 | Input bytes, device i at bits 8i+7:8i |
| dev_ok | output | N_DEV | Per-device healthy verdict |
| crc_err | output | N_DEV | Per-device CRC mismatch |
| overtemp | output | N_DEV | Per-device overtemperature |
| uv_alarm | output | N_DEV | Per-device undervoltage alarm |
| uv_warn | output | N_DEV | Per-device undervoltage warning |
| fault_seen | output | N_DEV | Per-device sampled fault pin |
| sel_bit | output | 1 | Selected input bit |
| sel_ok | output | 1 | Selected bit is from a healthy device |

## Verification
Some rules are checked by assertions on every cycle:
- the serial clock stays low while chip select is high, and `done` only follows a low chip select;
- a captured fault pin or overtemperature always clears the verdict, and input-only captures leave the status flags clear;
- results hold between captures, and the latched mode stays put while busy;
- an unhealthy or out-of-range selection never yields a 1.

Other rules can only be shown by the bench scenarios. These are the CRC match over every input byte value, the byte positions in both modes, and the exact transfer length. The same goes for the full pattern of status bits against fault pins with and without `ignore_uv`, the shared-pin variant, and the complete index sweep.

// File: rtl/serin_pkg.sv
// Package: shared types and the check-code function for the serializer
// readout controller. Assumes 8-bit input bytes and a 5-bit check code.
package serin_pkg;

    // Generator x^5+x^4+x^2+1 without the x^5 term
    localparam logic [4:0] CRC5_GEN = 5'h15;

    // Per-device decoded flags, captured at the end of a transfer
    typedef struct packed {
        logic crc;
        logic ot;
        logic uva;
        logic uvw;
        logic flt;
    } dev_flags_t;

    // Serial LFSR form of the check code, MSB first, zero start value
    function automatic logic [4:0] crc5_byte(input logic [7:0] data);
        logic [4:0] r;
        logic       fb;
        r = 5'd0;
        for (int b = 7; b >= 0; b--) begin
            fb = r[4] ^ data[b];
            r  = {r[3:0], 1'b0} ^ (fb ? CRC5_GEN : 5'd0);
        end
        return r;
    endfunction

endpackage

// File: rtl/serin_spi_rx.sv
// Receive-only SPI master, mode 0. Runs one transfer of nbytes bytes on a
// start pulse, holding chip select low, and stores byte p (p = 0 first
// received) at rx_bytes[8p+7:8p]. Assumes nbytes is 1..MAX_BYTES and that
// start is only honoured when idle (the caller gates it).
module serin_spi_rx #(
    parameter int MAX_BYTES = 6,
    parameter int CLK_DIV   = 2,
    localparam int BYTE_W   = $clog2(MAX_BYTES + 1),
    localparam int DIV_W    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [BYTE_W-1:0]      nbytes,
    input  logic                   miso,
    output logic                   sclk,
    output logic                   cs_n,
    output logic                   busy,
    output logic                   done,
    output logic [MAX_BYTES*8-1:0] rx_bytes
);

    logic [DIV_W-1:0]  div_cnt;
    logic [2:0]        bit_cnt;
    logic [BYTE_W-1:0] byte_cnt;
    logic [BYTE_W-1:0] nbytes_q;
    logic [6:0]        shift_q;
    logic              sclk_q;
    logic              cs_n_q;
    logic              busy_q;
    logic              done_q;
    logic              half_end;
    logic              byte_fin;

    assign half_end = (div_cnt == DIV_W'(CLK_DIV - 1));
    assign byte_fin = busy_q && half_end && !sclk_q && (bit_cnt == 3'd7);

    // Transfer sequencer: clock divider, bit and byte counters, framing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt  <= '0;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            nbytes_q <= '0;
            shift_q  <= '0;
            sclk_q   <= 1'b0;
            cs_n_q   <= 1'b1;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q   <= 1'b1;
                    cs_n_q   <= 1'b0;
                    sclk_q   <= 1'b0;
                    div_cnt  <= '0;
                    bit_cnt  <= '0;
                    byte_cnt <= '0;
                    nbytes_q <= nbytes;
                end
            end else if (half_end) begin
                div_cnt <= '0;
                if (!sclk_q) begin
                    sclk_q  <= 1'b1;
                    shift_q <= {shift_q[5:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    if (bit_cnt == 3'd7) begin
                        bit_cnt <= '0;
                        if (byte_cnt == nbytes_q - BYTE_W'(1)) begin
                            busy_q <= 1'b0;
                            cs_n_q <= 1'b1;
                            done_q <= 1'b1;
                        end else begin
                            byte_cnt <= byte_cnt + BYTE_W'(1);
                        end
                    end else begin
                        bit_cnt <= bit_cnt + 3'd1;
                    end
                end
            end else begin
                div_cnt <= div_cnt + DIV_W'(1);
            end
        end
    end

    // Byte store: writes each completed byte into its stream position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_bytes <= '0;
        end else if (byte_fin) begin
            for (int p = 0; p < MAX_BYTES; p++) begin
                if (byte_cnt == BYTE_W'(p)) begin
                    rx_bytes[p*8 +: 8] <= {shift_q, miso};
                end
            end
        end
    end

    assign sclk = sclk_q;
    assign cs_n = cs_n_q;
    assign busy = busy_q;
    assign done = done_q;

    // R2
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_q |-> !sclk_q);

    // R1
    done_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (cs_n_q && !$past(cs_n_q)));

endmodule

// File: rtl/serin_dev_qual.sv
// Per-device qualifier: decodes one device's input and status bytes,
// checks the 5-bit code, and captures flags and the healthy verdict when
// capture is high. Assumes in_byte, st_byte and fault_pin are stable in
// the capture cycle; st_byte is ignored when mode16 is 0.
module serin_dev_qual
    import serin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture,
    input  logic       mode16,
    input  logic       ign,
    input  logic [7:0] in_byte,
    input  logic [7:0] st_byte,
    input  logic       fault_pin,
    output logic [7:0] in_q,
    output dev_flags_t flags_q,
    output logic       ok_q
);

    dev_flags_t flags_d;
    logic       ok_d;

    // Decode of status bits and check code for the current stream
    always_comb begin
        flags_d.crc = mode16 && (st_byte[7:3] != crc5_byte(in_byte));
        flags_d.ot  = mode16 && st_byte[1];
        flags_d.uva = mode16 && !st_byte[2];
        flags_d.uvw = mode16 && !st_byte[0];
        flags_d.flt = fault_pin;
        ok_d = !((!ign && fault_pin) || flags_d.crc || flags_d.ot ||
                 (!ign && flags_d.uva));
    end

    // Result registers, loaded only at the end of a transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q    <= '0;
            flags_q <= '0;
            ok_q    <= 1'b0;
        end else if (capture) begin
            in_q    <= in_byte;
            flags_q <= flags_d;
            ok_q    <= ok_d;
        end
    end

    // R5
    eightbit_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !mode16) |=> (!flags_q.crc && !flags_q.ot &&
                                  !flags_q.uva && !flags_q.uvw));

    // R7
    fault_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && fault_pin && !ign) |=> !ok_q);

    // R6
    overtemp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && mode16 && st_byte[1]) |=> !ok_q);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(ok_q) && $stable(in_q) && $stable(flags_q)));

endmodule

// File: rtl/serin_chain_reader.sv
// Top: readout controller for a daisy chain of N_DEV input serializers.
// Starts a transfer on rd_req when idle, latches the mode and the
// undervoltage option, splits the stream per device, qualifies each
// device and serves single-bit reads by global index. Assumes the chain
// shifts out device 0's bytes first and fault pins are high-active.
module serin_chain_reader
    import serin_pkg::*;
#(
    parameter int N_DEV        = 3,
    parameter int CLK_DIV      = 2,
    parameter bit SHARED_FAULT = 1'b0,
    localparam int MAX_BYTES   = 2 * N_DEV,
    localparam int BYTE_W      = $clog2(MAX_BYTES + 1),
    localparam int TOTAL       = N_DEV * 8,
    localparam int IDX_W       = $clog2(TOTAL),
    localparam int FLT_W       = SHARED_FAULT ? 1 : N_DEV
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_req,
    input  logic               mode16,
    input  logic               ignore_uv,
    input  logic [FLT_W-1:0]   fault_in,
    input  logic               miso,
    input  logic [IDX_W-1:0]   sel_idx,
    output logic               spi_sclk,
    output logic               spi_cs_n,
    output logic               busy,
    output logic               done,
    output logic [TOTAL-1:0]   in_bits,
    output logic [N_DEV-1:0]   dev_ok,
    output logic [N_DEV-1:0]   crc_err,
    output logic [N_DEV-1:0]   overtemp,
    output logic [N_DEV-1:0]   uv_alarm,
    output logic [N_DEV-1:0]   uv_warn,
    output logic [N_DEV-1:0]   fault_seen,
    output logic               sel_bit,
    output logic               sel_ok
);

    logic                   start;
    logic                   mode_q;
    logic                   ign_q;
    logic [BYTE_W-1:0]      nbytes;
    logic [MAX_BYTES*8-1:0] rx_bytes;
    logic [N_DEV-1:0]       pin_vec;
    logic [7:0]             in_w [N_DEV];
    dev_flags_t             flags_w [N_DEV];
    logic [N_DEV-1:0]       ok_w;

    assign start  = rd_req && !busy;
    assign nbytes = mode16 ? BYTE_W'(2 * N_DEV) : BYTE_W'(N_DEV);

    // Configuration latch: mode and option are frozen per transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            ign_q  <= 1'b0;
        end else if (start) begin
            mode_q <= mode16;
            ign_q  <= ignore_uv;
        end
    end

    serin_spi_rx #(
        .MAX_BYTES (MAX_BYTES),
        .CLK_DIV   (CLK_DIV)
    ) spi_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .nbytes   (nbytes),
        .miso     (miso),
        .sclk     (spi_sclk),
        .cs_n     (spi_cs_n),
        .busy     (busy),
        .done     (done),
        .rx_bytes (rx_bytes)
    );

    // Fault pin fan-out: one shared pin or one pin per device
    generate
        if (SHARED_FAULT) begin : g_shared_pin
            assign pin_vec = {N_DEV{fault_in[0]}};
        end else begin : g_per_dev_pin
            assign pin_vec = fault_in;
        end
    endgenerate

    // One qualifier per device, fed from its stream positions
    generate
        for (genvar i = 0; i < N_DEV; i++) begin : g_dev
            logic [7:0] in_sel;
            assign in_sel = mode_q ? rx_bytes[(2*i)*8 +: 8] : rx_bytes[i*8 +: 8];

            serin_dev_qual qual_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .capture   (done),
                .mode16    (mode_q),
                .ign       (ign_q),
                .in_byte   (in_sel),
                .st_byte   (rx_bytes[(2*i+1)*8 +: 8]),
                .fault_pin (pin_vec[i]),
                .in_q      (in_w[i]),
                .flags_q   (flags_w[i]),
                .ok_q      (ok_w[i])
            );

            assign in_bits[i*8 +: 8] = in_w[i];
            assign crc_err[i]        = flags_w[i].crc;
            assign overtemp[i]       = flags_w[i].ot;
            assign uv_alarm[i]       = flags_w[i].uva;
            assign uv_warn[i]        = flags_w[i].uvw;
            assign fault_seen[i]     = flags_w[i].flt;
        end
    endgenerate

    assign dev_ok = ok_w;

    // Read port: picks device k/8, bit k%8, masked by the verdict
    always_comb begin
        sel_bit = 1'b0;
        sel_ok  = 1'b0;
        for (int d = 0; d < N_DEV; d++) begin
            if ((int'(sel_idx) >> 3) == d) begin
                sel_ok  = ok_w[d];
                sel_bit = ok_w[d] && in_w[d][sel_idx[2:0]];
            end
        end
    end

    // R11
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_req) |=> ($stable(mode_q) && $stable(ign_q)));

    // R9
    masked_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_ok |-> !sel_bit);

    // R9
    index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel_idx) >= TOTAL) |-> !sel_ok);

endmodule

// File: tb/serin_chain_reader_tb_top.sv
// Bench: sweeps input bytes, status patterns, fault pins, both modes, the
// option and the index range on a three-device chain; a behavioural
// serializer chain feeds miso. Expected values are computed here.
module serin_chain_reader_tb_top;

    localparam int N  = 3;
    localparam int NB = 2 * N;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_req = 1'b0;
    logic mode16 = 1'b1;
    logic ign = 1'b0;
    logic [N-1:0] fault_pv = '0;
    logic [0:0] fault_sh = '0;
    logic miso;
    logic [4:0] sel_idx = '0;

    logic sclk, cs_n, busy, done, sel_bit, sel_ok;
    logic [N*8-1:0] in_bits;
    logic [N-1:0] dev_ok, crc_err, ot, uva, uvw, flt;

    logic sclk_s, cs_n_s, busy_s, done_s, sel_bit_s, sel_ok_s;
    logic [N*8-1:0] in_bits_s;
    logic [N-1:0] dev_ok_s, crc_err_s, ot_s, uva_s, uvw_s, flt_s;

    int nvec = 0;
    int nfail = 0;
    int rise_cnt = 0;
    int cs_fall = 0;
    int bp = 0;
    logic [7:0] tx_byte [NB];
    logic [7:0] exp_in [N];
    logic [N-1:0] exp_ok;

    always #2.5 clk = ~clk;

    serin_chain_reader #(.N_DEV(N), .CLK_DIV(2), .SHARED_FAULT(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .mode16(mode16),
        .ignore_uv(ign), .fault_in(fault_pv), .miso(miso), .sel_idx(sel_idx),
        .spi_sclk(sclk), .spi_cs_n(cs_n), .busy(busy), .done(done),
        .in_bits(in_bits), .dev_ok(dev_ok), .crc_err(crc_err),
        .overtemp(ot), .uv_alarm(uva), .uv_warn(uvw), .fault_seen(flt),
        .sel_bit(sel_bit), .sel_ok(sel_ok)
    );

    serin_chain_reader #(.N_DEV(N), .CLK_DIV(2), .SHARED_FAULT(1'b1)) dut_sh_i (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .mode16(mode16),
        .ignore_uv(ign), .fault_in(fault_sh), .miso(miso), .sel_idx(sel_idx),
        .spi_sclk(sclk_s), .spi_cs_n(cs_n_s), .busy(busy_s), .done(done_s),
        .in_bits(in_bits_s), .dev_ok(dev_ok_s), .crc_err(crc_err_s),
        .overtemp(ot_s), .uv_alarm(uva_s), .uv_warn(uvw_s), .fault_seen(flt_s),
        .sel_bit(sel_bit_s), .sel_ok(sel_ok_s)
    );

    // Behavioural chain: next bit after each falling serial clock
    always @(posedge cs_n or negedge sclk) begin
        if (cs_n === 1'b1) bp = 0;
        else bp = bp + 1;
    end
    assign miso = (bp < NB * 8) ? tx_byte[bp / 8][7 - (bp % 8)] : 1'b0;

    always @(posedge sclk) rise_cnt++;
    always @(negedge cs_n) cs_fall++;

    // Check-code by polynomial long division (generator 6'b110101)
    function automatic logic [4:0] ref_crc(input logic [7:0] d);
        logic [12:0] r;
        r = {d, 5'b0};
        for (int b = 12; b >= 5; b--) begin
            if (r[b]) r = r ^ (13'h35 << (b - 5));
        end
        return r[4:0];
    endfunction

    function automatic logic [7:0] mk_status(input logic [7:0] d,
                                             input logic [2:0] low,
                                             input logic [4:0] err);
        return {ref_crc(d) ^ err, low};
    endfunction

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue a request and return one cycle after done (results settled)
    task automatic run_read(input logic m16, input logic ig,
                            input logic [N-1:0] fp);
        mode16 = m16;
        ign = ig;
        fault_pv = fp;
        fault_sh = fp[0];
        bp = 0;
        rise_cnt = 0;
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        while (done !== 1'b1) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(input logic m16, input logic ig,
                             input logic [N-1:0] fp);
        logic [N*8-1:0] e_in;
        logic [N-1:0] e_crc, e_ot, e_uva, e_uvw, e_ok, e_ok_sh;
        for (int i = 0; i < N; i++) begin
            logic [7:0] inb, stb;
            inb = m16 ? tx_byte[2*i] : tx_byte[i];
            stb = tx_byte[2*i+1];
            e_in[i*8 +: 8] = inb;
            exp_in[i] = inb;
            e_crc[i] = m16 && (stb[7:3] != ref_crc(inb));
            e_ot[i]  = m16 && stb[1];
            e_uva[i] = m16 && !stb[2];
            e_uvw[i] = m16 && !stb[0];
            e_ok[i]  = !((!ig && fp[i]) || e_crc[i] || e_ot[i] || (!ig && e_uva[i]));
            e_ok_sh[i] = !((!ig && fp[0]) || e_crc[i] || e_ot[i] || (!ig && e_uva[i]));
        end
        exp_ok = e_ok;
        chk("R1 serial clock edges", rise_cnt, (m16 ? NB : N) * 8);
        chk("R3 input bytes", in_bits, e_in);
        chk("R4 crc_err", crc_err, e_crc);
        chk("R5 overtemp", ot, e_ot);
        chk("R5 uv_alarm", uva, e_uva);
        chk("R5 uv_warn", uvw, e_uvw);
        chk("R6 R7 dev_ok", dev_ok, e_ok);
        chk("R8 fault_seen", flt, fp);
        chk("R8 shared pin dev_ok", dev_ok_s, e_ok_sh);
    endtask

    task automatic sel_sweep();
        for (int k = 0; k < 32; k++) begin
            logic e_ok_k, e_bit_k;
            sel_idx = 5'(k);
            #1;
            if (k < N * 8) begin
                e_ok_k  = exp_ok[k / 8];
                e_bit_k = e_ok_k && exp_in[k / 8][k % 8];
            end else begin
                e_ok_k  = 1'b0;
                e_bit_k = 1'b0;
            end
            chk("R9 sel_ok", sel_ok, e_ok_k);
            chk("R9 sel_bit", sel_bit, e_bit_k);
        end
    endtask

    // Watchdog: an expired run is a failed check and still summarises
    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NB; i++) tx_byte[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 cs_n after reset", cs_n, 1);
        chk("R2 sclk idle low", sclk, 0);
        chk("R10 busy after reset", busy, 0);
        chk("R10 dev_ok after reset", dev_ok, 0);
        chk("R10 in_bits after reset", in_bits, 0);
        chk("R10 flags after reset", {crc_err, ot, uva, uvw, flt}, 0);
        chk("R9 sel_ok after reset", sel_ok, 0);

        // R4 every input byte value; device 2 carries a corrupted code
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b0, b1, b2;
            b0 = 8'(v);
            b1 = 8'(v) ^ 8'h5A;
            b2 = ~8'(v);
            tx_byte[0] = b0; tx_byte[1] = mk_status(b0, 3'b101, 5'd0);
            tx_byte[2] = b1; tx_byte[3] = mk_status(b1, 3'b101, 5'd0);
            tx_byte[4] = b2; tx_byte[5] = mk_status(b2, 3'b101, 5'(1 << (v % 5)));
            run_read(1'b1, 1'b0, 3'b000);
            check_all(1'b1, 1'b0, 3'b000);
            chk("R4 corrupted code flagged", crc_err, 3'b100);
        end

        // R5 R6 R7 R8 status bits against fault pins, option on and off
        for (int s = 0; s < 8; s++) begin
            for (int ig = 0; ig < 2; ig++) begin
                for (int fp = 0; fp < 8; fp++) begin
                    for (int i = 0; i < N; i++) begin
                        logic [7:0] d;
                        d = 8'(s * 37 + i * 11 + fp * 5 + ig);
                        tx_byte[2*i]   = d;
                        tx_byte[2*i+1] = mk_status(d, 3'((s + i) % 8), 5'd0);
                    end
                    run_read(1'b1, 1'(ig), 3'(fp));
                    check_all(1'b1, 1'(ig), 3'(fp));
                    if (fp == 3) sel_sweep();
                end
            end
        end

        // R3 R5 input-only mode
        for (int ig = 0; ig < 2; ig++) begin
            for (int fp = 0; fp < 8; fp++) begin
                for (int i = 0; i < NB; i++) tx_byte[i] = 8'(fp * 29 + i * 67 + ig);
                run_read(1'b0, 1'(ig), 3'(fp));
                check_all(1'b0, 1'(ig), 3'(fp));
                if (fp == 5) sel_sweep();
            end
        end

        // R11 R10 request and mode change during a transfer are ignored
        for (int i = 0; i < N; i++) begin
            tx_byte[2*i]   = 8'hC3 ^ 8'(i);
            tx_byte[2*i+1] = mk_status(8'hC3 ^ 8'(i), 3'b101, 5'd0);
        end
        begin
            logic [N-1:0] ok_before;
            ok_before = dev_ok;
            mode16 = 1'b1; ign = 1'b0; fault_pv = '0; fault_sh = '0;
            bp = 0; rise_cnt = 0; cs_fall = 0;
            @(negedge clk); rd_req = 1'b1;
            @(negedge clk); rd_req = 1'b0;
            repeat (40) @(negedge clk);
            chk("R10 dev_ok held mid-transfer", dev_ok, ok_before);
            rd_req = 1'b1; mode16 = 1'b0; ign = 1'b1;
            @(negedge clk); rd_req = 1'b0;
            while (done !== 1'b1) @(negedge clk);
            @(negedge clk);
            check_all(1'b1, 1'b0, 3'b000);
            repeat (30) @(negedge clk);
            chk("R11 single transfer only", cs_fall, 1);
            chk("R1 cs_n high after done", cs_n, 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule